// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block lets an external controller read and write a small bank of 8-bit configuration registers over a three-wire serial link: an active-low select, a serial clock and one data line that changes direction. The data line is split at the pad into an input, an output and an output enable. The select, clock and data pins are brought into the system clock domain through synchronizers and then oversampled. The serial clock's high and low phases must each last at least `SYNC_STAGES + 2` system clock cycles.

Every transfer opens with a 16-bit command word. The command sets the direction, a burst length code and a 13-bit start address. Data bytes follow, and the address advances by one after each byte. The format register gets its start-up value from the levels on the serial clock and data pins while reset is held. This lets a board strap the default output format without any serial traffic. The full register contents are presented in parallel to the logic that uses them.

Top module: `cfgreg_spi_slave`

## Requirements
- R1: The command word is the first 16 bits after select falls. It is captured MSB first on rising serial clock edges. Bit 15 is the direction (1 = read, 0 = write), bits 14:13 are the length code and bits 12:0 are the start address.
- R2: Length code 00 transfers 1 byte, 01 transfers 2 and 10 transfers 3. After that many bytes, further clocks write nothing and the data line is not driven. Code 11 keeps transferring bytes until select rises.
- R3: After each complete data byte the register address increases by one, wrapping from 1FFFh to 0000h.
- R4: The implemented registers are listed by address, with a bit mask per register: 0005h mask 03h, 0008h mask 0Fh, 0011h mask 0Bh, 0012h mask FFh, 0014h mask 07h, 0020h mask 0Fh, 0022h mask 77h. A write stores data AND mask. Bits outside the mask always read back as 0.
- R5: A write to any other address changes no register. A read from any other address returns 00h.
- R6: During read data bytes the slave drives data MSB first and updates it on falling serial clock edges. `sdio_oe` is high only in the data phase of a read.
- R7: While select is high, `sdio_oe` is low.
- R8: Select rising at any point ends the transfer. A partly shifted byte or command is discarded, and bytes already completed stay written.
- R9: While `rst` is high, format register 0011h loads from the pins. Bit 0 takes the `sclk_i` level (0 = offset binary, 1 = two's complement), bit 3 takes the `sdio_i` level (1 = double-data-rate output, 0 = parallel) and its other bits are 0.
- R10: Reset clears every register other than 0011h to 00h and leaves `sdio_oe` low.
- R11: `cfg_regs_o` holds the registers in ascending address order. 0005h is in bits 7:0, 0008h in 15:8, and so on up to 0022h in 55:48.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; also the strap capture window |
| cs_n_i | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial clock; start-up format strap |
| sdio_i | input | 1 | Serial data from pad; start-up output-mode strap |
| sdio_o | output | 1 | Serial read data to pad |
| sdio_oe | output | 1 | Pad output enable for serial data |
| cfg_regs_o | output | 56 | All registers in parallel, ascending address order |

## Verification
The bench targets burst boundaries. A single-byte write followed by extra clocks would corrupt the next address if the length count were off by one, and a wrong count on reads would show up as a driven data line after the last byte. A burst that crosses 1FFFh checks that the address counter wraps instead of stopping or widening. The bench also aborts transfers in the middle of a byte and in the middle of the command: committing a partial byte or keeping stale command bits would leave a wrong value in a register that is later read back. Reserved bits, unimplemented addresses and both strap levels are swept, since a missing mask or a hole in the decode shows up directly in the read data.

// File: rtl/cfgreg_spi_pkg.sv
package cfgreg_spi_pkg;

    localparam int ADDR_W    = 13;
    localparam int BYTE_W    = 8;
    localparam int CMD_W     = 1 + 2 + ADDR_W;
    localparam int CNT_W     = $clog2(CMD_W);
    localparam int NUM_REGS  = 7;
    localparam int IDX_W     = $clog2(NUM_REGS);
    localparam int FMT_IDX   = 2;
    localparam logic [1:0] LEN_OPEN = 2'b11;
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(BYTE_W - 1);

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_DATA = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    typedef struct packed {
        logic              rd;
        logic [1:0]        len;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } lookup_t;

    function automatic logic [ADDR_W-1:0] reg_addr(input int i);
        case (i)
            0:       return ADDR_W'(13'h0005);
            1:       return ADDR_W'(13'h0008);
            2:       return ADDR_W'(13'h0011);
            3:       return ADDR_W'(13'h0012);
            4:       return ADDR_W'(13'h0014);
            5:       return ADDR_W'(13'h0020);
            default: return ADDR_W'(13'h0022);
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] reg_mask(input int i);
        case (i)
            0:       return 8'h03;
            1:       return 8'h0F;
            2:       return 8'h0B;
            3:       return 8'hFF;
            4:       return 8'h07;
            5:       return 8'h0F;
            default: return 8'h77;
        endcase
    endfunction

    function automatic lookup_t reg_lookup(input logic [ADDR_W-1:0] a);
        lookup_t r;
        r = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (a == reg_addr(i)) begin
                r.hit = 1'b1;
                r.idx = IDX_W'(i);
            end
        end
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] strap_value(input logic fmt_pin, input logic ddr_pin);
        return {4'b0000, ddr_pin, 1'b0, 1'b0, fmt_pin};
    endfunction

endpackage

// File: rtl/cfgreg_pin_sync.sv
module cfgreg_pin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] ff_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) ff_q <= RST_VAL;
                else     ff_q <= d_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) ff_q <= {STAGES{RST_VAL}};
                else     ff_q <= {ff_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/cfgreg_frame_ctl.sv
module cfgreg_frame_ctl
    import cfgreg_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_act_i,
    input  logic              sclk_i,
    input  logic              dat_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic              wr_vld_o,
    output wr_req_t           wr_o,
    output logic              sdo_o,
    output logic              drive_o,
    output phase_e            phase_o,
    output logic              byte_done_o,
    output logic              sclk_fall_o
);
    logic              sclk_d;
    logic              rise_w, fall_w;
    phase_e            phase_q;
    logic [CNT_W-1:0]  bit_q;
    logic [CMD_W-1:0]  sh_q;
    cmd_t              cmd_q, cmd_w;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        nbyte_q;
    logic [BYTE_W-1:0] tx_q, rx_w;
    logic              sdo_q, drive_q, wr_vld_q, last_w;
    wr_req_t           wr_q;

    assign rise_w = sclk_i & ~sclk_d;
    assign fall_w = ~sclk_i & sclk_d;
    assign cmd_w  = cmd_t'({sh_q[CMD_W-2:0], dat_i});
    assign rx_w   = {sh_q[BYTE_W-2:0], dat_i};
    assign last_w = (cmd_q.len != LEN_OPEN) && (nbyte_q == cmd_q.len);
    assign byte_done_o = cs_act_i && rise_w && (phase_q == PH_DATA) && (bit_q == BYTE_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d   <= 1'b0;
            phase_q  <= PH_CMD;
            bit_q    <= '0;
            sh_q     <= '0;
            cmd_q    <= '0;
            addr_q   <= '0;
            nbyte_q  <= '0;
            tx_q     <= '0;
            sdo_q    <= 1'b0;
            drive_q  <= 1'b0;
            wr_vld_q <= 1'b0;
            wr_q     <= '0;
        end else begin
            sclk_d   <= sclk_i;
            wr_vld_q <= 1'b0;
            if (!cs_act_i) begin
                phase_q <= PH_CMD;
                bit_q   <= '0;
                nbyte_q <= '0;
                drive_q <= 1'b0;
            end else if (rise_w) begin
                sh_q <= {sh_q[CMD_W-2:0], dat_i};
                case (phase_q)
                    PH_CMD: begin
                        if (bit_q == CMD_LAST) begin
                            cmd_q   <= cmd_w;
                            addr_q  <= cmd_w.addr;
                            phase_q <= PH_DATA;
                            bit_q   <= '0;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                    PH_DATA: begin
                        if (bit_q == BYTE_LAST) begin
                            wr_vld_q   <= ~cmd_q.rd;
                            wr_q.addr  <= addr_q;
                            wr_q.data  <= rx_w;
                            addr_q     <= addr_q + 1'b1;
                            bit_q      <= '0;
                            nbyte_q    <= nbyte_q + 1'b1;
                            if (last_w) begin
                                phase_q <= PH_DONE;
                                drive_q <= 1'b0;
                            end
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end else if (fall_w && phase_q == PH_DATA && cmd_q.rd) begin
                drive_q <= 1'b1;
                if (bit_q == '0) begin
                    sdo_q <= rd_data_i[BYTE_W-1];
                    tx_q  <= {rd_data_i[BYTE_W-2:0], 1'b0};
                end else begin
                    sdo_q <= tx_q[BYTE_W-1];
                    tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    assign cur_addr_o  = addr_q;
    assign wr_vld_o    = wr_vld_q;
    assign wr_o        = wr_q;
    assign sdo_o       = sdo_q;
    assign drive_o     = drive_q;
    assign phase_o     = phase_q;
    assign sclk_fall_o = fall_w;
endmodule

// File: rtl/cfgreg_bank.sv
module cfgreg_bank
    import cfgreg_spi_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       strap_fmt_i,
    input  logic                       strap_ddr_i,
    input  logic                       wr_vld_i,
    input  wr_req_t                    wr_i,
    input  logic [ADDR_W-1:0]          rd_addr_i,
    output logic [BYTE_W-1:0]          rd_data_o,
    output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
    logic [BYTE_W-1:0] regs_q [NUM_REGS];
    lookup_t           wr_hit_w, rd_hit_w;

    assign wr_hit_w = reg_lookup(wr_i.addr);
    assign rd_hit_w = reg_lookup(rd_addr_i);

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    if (g == FMT_IDX) regs_q[g] <= strap_value(strap_fmt_i, strap_ddr_i);
                    else              regs_q[g] <= '0;
                end else if (wr_vld_i && wr_hit_w.hit && wr_hit_w.idx == IDX_W'(g)) begin
                    regs_q[g] <= wr_i.data & reg_mask(g);
                end
            end
            assign regs_o[g*BYTE_W +: BYTE_W] = regs_q[g];
        end
    endgenerate

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_hit_w.hit && rd_hit_w.idx == IDX_W'(i)) rd_data_o = regs_q[i];
        end
    end
endmodule

// File: rtl/cfgreg_spi_slave.sv
module cfgreg_spi_slave
    import cfgreg_spi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cs_n_i,
    input  logic                       sclk_i,
    input  logic                       sdio_i,
    output logic                       sdio_o,
    output logic                       sdio_oe,
    output logic [NUM_REGS*BYTE_W-1:0] cfg_regs_o
);
    logic              cs_n_s, sclk_s, sdio_s, cs_act;
    logic [BYTE_W-1:0] rd_data;
    logic [ADDR_W-1:0] cur_addr;
    logic              wr_vld, drive_w, byte_done, sclk_fall;
    wr_req_t           wr_req;
    phase_e            phase;

    cfgreg_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
        .clk(clk), .rst(rst), .d_i(cs_n_i), .q_o(cs_n_s));
    cfgreg_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
        .clk(clk), .rst(rst), .d_i(sclk_i), .q_o(sclk_s));
    cfgreg_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdio (
        .clk(clk), .rst(rst), .d_i(sdio_i), .q_o(sdio_s));

    assign cs_act = ~cs_n_s;

    cfgreg_frame_ctl u_frame (
        .clk(clk), .rst(rst), .cs_act_i(cs_act), .sclk_i(sclk_s), .dat_i(sdio_s),
        .rd_data_i(rd_data), .cur_addr_o(cur_addr), .wr_vld_o(wr_vld), .wr_o(wr_req),
        .sdo_o(sdio_o), .drive_o(drive_w), .phase_o(phase), .byte_done_o(byte_done),
        .sclk_fall_o(sclk_fall));

    cfgreg_bank u_bank (
        .clk(clk), .rst(rst), .strap_fmt_i(sclk_i), .strap_ddr_i(sdio_i),
        .wr_vld_i(wr_vld), .wr_i(wr_req), .rd_addr_i(cur_addr), .rd_data_o(rd_data),
        .regs_o(cfg_regs_o));

    assign sdio_oe = ~cs_n_i & drive_w;
endmodule

// File: rtl/cfgreg_spi_slave_chk.sv
module cfgreg_spi_slave_chk
    import cfgreg_spi_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic                       sclk_i,
    input logic                       sdio_i,
    input logic                       sdio_o,
    input logic                       sdio_oe,
    input logic [NUM_REGS*BYTE_W-1:0] cfg_regs_o,
    input logic                       cs_act,
    input logic                       byte_done,
    input logic                       sclk_fall,
    input logic                       wr_vld,
    input logic [ADDR_W-1:0]          cur_addr,
    input phase_e                     phase
);
    p_no_drive_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !cs_act |-> !sdio_oe);

    p_quiet_after_burst_r2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DONE) |-> !sdio_oe);

    p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
        byte_done |=> cur_addr == ADDR_W'($past(cur_addr) + 1'b1));

    p_drive_on_fall_r6: assert property (@(posedge clk) disable iff (rst)
        !sclk_fall |=> $stable(sdio_o));

    p_reserved_zero_r4: assert property (@(posedge clk) disable iff (rst)
        cfg_regs_o[15:12] == 4'b0000);

    p_whole_byte_only_r8: assert property (@(posedge clk) disable iff (rst)
        wr_vld |-> $past(byte_done));

    p_strap_load_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> cfg_regs_o[23:16] == {4'b0000, $past(sdio_i), 2'b00, $past(sclk_i)});
endmodule

bind cfgreg_spi_slave cfgreg_spi_slave_chk u_chk (
    .clk(clk), .rst(rst), .sclk_i(sclk_i), .sdio_i(sdio_i), .sdio_o(sdio_o),
    .sdio_oe(sdio_oe), .cfg_regs_o(cfg_regs_o), .cs_act(cs_act), .byte_done(byte_done),
    .sclk_fall(sclk_fall), .wr_vld(wr_vld), .cur_addr(cur_addr), .phase(phase));

// File: tb/cfgreg_spi_slave_bench.sv
module cfgreg_spi_slave_bench;
    localparam int H = 6;
    localparam int NR = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdio_m = 1'b0;
    logic        sdio_o, sdio_oe;
    logic [55:0] cfg_regs;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    logic [7:0] expv [NR];
    logic [7:0] wbuf [8];
    logic [7:0] rbuf [8];
    bit         oe_all [8];
    bit         oe_any [8];

    always #2 clk = ~clk;

    cfgreg_spi_slave u_cfgreg_spi_slave (
        .clk(clk), .rst(rst), .cs_n_i(cs_n), .sclk_i(sclk), .sdio_i(sdio_m),
        .sdio_o(sdio_o), .sdio_oe(sdio_oe), .cfg_regs_o(cfg_regs));

    function automatic int idx_of(input logic [12:0] a);
        case (a)
            13'h0005: return 0;
            13'h0008: return 1;
            13'h0011: return 2;
            13'h0012: return 3;
            13'h0014: return 4;
            13'h0020: return 5;
            13'h0022: return 6;
            default:  return -1;
        endcase
    endfunction

    function automatic logic [7:0] mask_of(input int i);
        case (i)
            0: return 8'h03;
            1: return 8'h0F;
            2: return 8'h0B;
            3: return 8'hFF;
            4: return 8'h07;
            5: return 8'h0F;
            default: return 8'h77;
        endcase
    endfunction

    function automatic logic [12:0] addr_of(input int i);
        case (i)
            0: return 13'h0005;
            1: return 13'h0008;
            2: return 13'h0011;
            3: return 13'h0012;
            4: return 13'h0014;
            5: return 13'h0020;
            default: return 13'h0022;
        endcase
    endfunction

    function automatic logic [7:0] exp_at(input logic [12:0] a);
        int i;
        i = idx_of(a);
        return (i < 0) ? 8'h00 : expv[i];
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < NR; i++)
            chk(req, $sformatf("cfg_regs_o byte %0d", i), int'(cfg_regs[i*8 +: 8]), int'(expv[i]));
    endtask

    task automatic do_reset(input bit fmt_lvl, input bit ddr_lvl);
        @(negedge clk);
        rst = 1'b1; cs_n = 1'b1; sclk = fmt_lvl; sdio_m = ddr_lvl;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        sclk = 1'b0; sdio_m = 1'b0;
        repeat (2 * H) @(negedge clk);
        for (int i = 0; i < NR; i++) expv[i] = 8'h00;
        expv[2] = {4'b0000, ddr_lvl, 2'b00, fmt_lvl};
    endtask

    task automatic bit_cycle(input bit v, output bit so, output bit oe);
        sclk = 1'b0; sdio_m = v;
        repeat (H) @(negedge clk);
        so = sdio_o; oe = sdio_oe;
        sclk = 1'b1;
        repeat (H) @(negedge clk);
    endtask

    task automatic txn(input bit rd, input logic [1:0] lc, input logic [12:0] a,
                       input int nb, input int cut);
        logic [15:0] cmd;
        int  sent;
        bit  so, oe;
        cmd = {rd, lc, a};
        sent = 0;
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
        for (int i = 15; i >= 0; i--) begin
            if (cut < 0 || sent < cut) begin
                bit_cycle(cmd[i], so, oe);
                sent++;
            end
        end
        for (int b = 0; b < nb; b++) begin
            rbuf[b] = 8'h00; oe_all[b] = 1'b1; oe_any[b] = 1'b0;
            for (int i = 7; i >= 0; i--) begin
                if (cut < 0 || sent < cut) begin
                    bit_cycle(wbuf[b][i], so, oe);
                    rbuf[b][i] = so;
                    if (oe) oe_any[b] = 1'b1; else oe_all[b] = 1'b0;
                    sent++;
                end
            end
        end
        sclk = 1'b0;
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        repeat (3 * H) @(negedge clk);
    endtask

    task automatic model_write(input logic [1:0] lc, input logic [12:0] a, input int nb, input int cut);
        int full, eff, ix;
        logic [12:0] ad;
        full = nb;
        if (cut >= 0) begin
            full = (cut >= 16) ? (cut - 16) / 8 : 0;
            if (full > nb) full = nb;
        end
        eff = (lc == 2'b11) ? full : ((full < int'(lc) + 1) ? full : int'(lc) + 1);
        for (int k = 0; k < eff; k++) begin
            ad = a + 13'(k);
            ix = idx_of(ad);
            if (ix >= 0) expv[ix] = wbuf[k] & mask_of(ix);
        end
    endtask

    task automatic wr(input string req, input logic [1:0] lc, input logic [12:0] a, input int nb, input int cut);
        txn(1'b0, lc, a, nb, cut);
        model_write(lc, a, nb, cut);
        chk("R7", "sdio_oe after write", int'(sdio_oe), 0);
        check_regs(req);
    endtask

    task automatic rd(input string req, input logic [1:0] lc, input logic [12:0] a, input int nb);
        int lim;
        for (int k = 0; k < 8; k++) wbuf[k] = 8'hA5;
        txn(1'b1, lc, a, nb, -1);
        lim = (lc == 2'b11) ? nb : int'(lc) + 1;
        for (int k = 0; k < nb; k++) begin
            if (k < lim) begin
                chk(req, $sformatf("read data @%0h", a + 13'(k)), int'(rbuf[k]), int'(exp_at(a + 13'(k))));
                chk("R6", "sdio_oe held through read byte", int'(oe_all[k]), 1);
            end else begin
                chk("R2", "sdio_oe beyond burst", int'(oe_any[k]), 0);
            end
        end
        chk("R7", "sdio_oe after read", int'(sdio_oe), 0);
        check_regs(req);
    endtask

    initial begin
        while (1) begin
            @(posedge clk);
            cyc++;
            if (cyc >= 190000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        // R9, R10, R11: both strap polarities
        do_reset(1'b1, 1'b0);
        check_regs("R9");
        chk("R10", "sdio_oe at reset", int'(sdio_oe), 0);
        do_reset(1'b0, 1'b1);
        check_regs("R9");
        do_reset(1'b0, 1'b0);
        check_regs("R10");

        // R1, R4, R6: per-register pattern sweep with single-byte write and read
        for (int i = 0; i < NR; i++) begin
            for (int p = 0; p < 8; p++) begin
                logic [7:0] pat;
                case (p)
                    0: pat = 8'hFF; 1: pat = 8'h00; 2: pat = 8'hA5; 3: pat = 8'h5A;
                    4: pat = 8'h01; 5: pat = 8'h80; 6: pat = 8'h3C; default: pat = 8'hC3;
                endcase
                wbuf[0] = pat;
                wr("R4", 2'b00, addr_of(i), 1, -1);
                rd("R1", 2'b00, addr_of(i), 1);
            end
        end

        // R5: unimplemented addresses
        for (int k = 0; k < 8; k++) wbuf[k] = 8'hFF;
        wr("R5", 2'b00, 13'h0006, 1, -1);
        wr("R5", 2'b00, 13'h1234, 1, -1);
        rd("R5", 2'b00, 13'h0013, 1);
        rd("R5", 2'b00, 13'h1FFF, 1);

        // R2: lengths with surplus clocks
        for (int k = 0; k < 8; k++) wbuf[k] = 8'h11 * 8'(k + 1);
        wr("R2", 2'b00, 13'h0011, 3, -1);
        wr("R2", 2'b01, 13'h0011, 3, -1);
        wr("R2", 2'b10, 13'h0011, 4, -1);
        rd("R2", 2'b00, 13'h0011, 2);
        rd("R2", 2'b01, 13'h0011, 3);
        rd("R2", 2'b10, 13'h0011, 4);
        for (int k = 0; k < 8; k++) wbuf[k] = 8'hF0 ^ 8'(k * 37);
        wr("R2", 2'b11, 13'h0011, 4, -1);
        rd("R2", 2'b11, 13'h0010, 6);

        // R3: burst across the top of the address space
        for (int k = 0; k < 8; k++) wbuf[k] = 8'h0E - 8'(k);
        wr("R3", 2'b11, 13'h1FFE, 8, -1);
        rd("R3", 2'b11, 13'h1FFF, 8);

        // R8: aborts inside a data byte and inside the command
        for (int k = 0; k < 8; k++) wbuf[k] = 8'h6D + 8'(k);
        wr("R8", 2'b11, 13'h0011, 3, 16 + 8 + 3);
        wr("R8", 2'b00, 13'h0012, 1, 10);
        wbuf[0] = 8'h96;
        wr("R8", 2'b00, 13'h0020, 1, 16 + 7);
        wr("R8", 2'b00, 13'h0020, 1, -1);
        rd("R8", 2'b11, 13'h0011, 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule